// File: doc/BRIEF.md
# UART Receive Buffer with Hysteresis Flow Control

This block sits between a UART's receive shift register and the host. Each received character is stored together with its three per-character error flags, so the error status stays attached to its byte as it moves through the queue. The host sees the oldest stored character and its flags at all times, and consumes it with a read strobe.

Two outputs are derived from the fill level. The first is a data-available interrupt, raised once the level reaches a programmable trigger. The second is an active-low ready-to-receive pin for hardware flow control. It is released when the level climbs to trigger plus a hysteresis margin, which pauses the remote transmitter. It is driven low again once the level drains to trigger minus the margin. Because the pin switches at two separate points, it does not chatter when the level hovers near the trigger.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the fill count is 0, `irq` is 0, `overrun` is 0 and `flow_n` is 0, meaning ready to receive.
- R2: Characters leave in the order they arrived. Each entry holds `{err[2:0], data[7:0]}`. The head entry appears on `rd_data` and `rd_err` before it is read, and `rd_err` sits in line-status positions 4 down to 2.
- R3: An accepted write raises `fill` by 1 and an accepted read lowers it by 1, both at the clock edge. `fill` never exceeds `DEPTH`.
- R4: A write while `fill` equals `DEPTH` is dropped and sets `overrun`. `overrun` stays at 1 until reset. A write and a read in the same cycle at full still drop the write, and `fill` falls by 1.
- R5: A read while the buffer is empty leaves `fill` at 0. While the buffer is empty, `rd_data` and `rd_err` show the last character that was read (0 before any read).
- R6: A write and a read in the same cycle with `0 < fill < DEPTH` leave `fill` unchanged and keep the order of R2.
- R7: `irq` equals `fifo_on & rx_irq_en & (fill >= trig)`, with no register delay. It drops as soon as `fill` falls below `trig`.
- R8: With flow control active, `flow_n` goes to 1 at the same edge where `fill` becomes greater than or equal to `trig + hyst`.
- R9: With flow control active, `flow_n` goes to 0 at the same edge where `fill` becomes less than or equal to `trig - hyst`. The lower threshold saturates at 0. Between the two thresholds `flow_n` keeps its previous value.
- R10: Flow control is active only when both `flow_feat_en` and `flow_mcr_en` are 1. Otherwise `flow_n` is 0 from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receive shift register |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags of the received character |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Head character |
| rd_err | output | 3 | Error flags of the head character |
| fill | output | $clog2(DEPTH+1) | Number of stored characters |
| overrun | output | 1 | Sticky flag for a dropped write |
| fifo_on | input | 1 | Buffer mode enable |
| rx_irq_en | input | 1 | Data-available interrupt enable |
| trig | input | $clog2(DEPTH+1) | Trigger level |
| hyst | input | $clog2(DEPTH+1) | Hysteresis margin |
| flow_feat_en | input | 1 | Enhanced-feature enable for flow control |
| flow_mcr_en | input | 1 | Flow-control enable from modem control |
| irq | output | 1 | Data-available interrupt |
| flow_n | output | 1 | Active-low ready-to-receive pin |

## Verification
The bench builds the buffer with `DEPTH` set to 16, trigger 8 and hysteresis 2, so the pin switches at 10 and at 6. With a depth this small, every full-buffer case is reached in a few dozen cycles: filling completely, writing while full, and reading and writing together at full. The bench also drains the buffer through both thresholds and into an empty read. The same sequence covers the hold band, the interrupt boundary, and the gating by each enable bit.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [2:0]    wr_err,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [2:0]    rd_err,
  output logic [CW-1:0] fill,
  output logic          overrun,
  input  logic          fifo_on,
  input  logic          rx_irq_en,
  input  logic [CW-1:0] trig,
  input  logic [CW-1:0] hyst,
  input  logic          flow_feat_en,
  input  logic          flow_mcr_en,
  output logic          irq,
  output logic          flow_n
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [10:0]   mem [DEPTH];
  logic [10:0]   last_q;
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_d;
  logic [CW:0]   hi;
  logic [CW-1:0] lo;
  logic          flow_q;

  wire empty  = (cnt == '0);
  wire do_rd  = rd_en && !empty;
  wire do_wr  = wr_en && (cnt != FULL);
  wire fc_on  = flow_feat_en && flow_mcr_en;
  wire [10:0] head = empty ? last_q : mem[rp];

  assign cnt_d   = cnt + CW'(do_wr) - CW'(do_rd);
  assign hi      = {1'b0, trig} + {1'b0, hyst};
  assign lo      = (trig > hyst) ? trig - hyst : '0;
  assign rd_data = head[7:0];
  assign rd_err  = head[10:8];
  assign fill    = cnt;
  assign irq     = fifo_on && rx_irq_en && (cnt >= trig);
  assign flow_n  = flow_q;

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= {wr_err, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      last_q  <= '0;
      overrun <= 1'b0;
      flow_q  <= 1'b0;
    end else begin
      cnt <= cnt_d;
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) begin
        rp     <= rp + 1'b1;
        last_q <= mem[rp];
      end
      if (wr_en && cnt == FULL) overrun <= 1'b1;
      if (!fc_on)                     flow_q <= 1'b0;
      else if ({1'b0, cnt_d} >= hi)   flow_q <= 1'b1;
      else if (cnt_d <= lo)           flow_q <= 1'b0;
    end
  end

endmodule

module uart_rx_buffer_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [CW-1:0] fill,
  input logic          overrun,
  input logic          irq,
  input logic          flow_n,
  input logic [CW-1:0] trig,
  input logic [CW-1:0] hyst,
  input logic          fifo_on,
  input logic          rx_irq_en,
  input logic          flow_feat_en,
  input logic          flow_mcr_en
);

  wire [CW:0] hi_c = {1'b0, trig} + {1'b0, hyst};
  wire [CW:0] lo_c = (trig > hyst) ? {1'b0, trig} - {1'b0, hyst} : '0;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH) && wr_en && !rd_en) |=> (fill == CW'(DEPTH) && overrun));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && rd_en && !wr_en) |=> fill == '0);

  p_rw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && fill != '0 && fill != CW'(DEPTH)) |=> $stable(fill));

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_on && rx_irq_en) |-> !irq);

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < trig) |-> !irq);

  p_flow_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flow_n) |-> ({1'b0, fill} >= hi_c));

  p_flow_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flow_n) |-> (({1'b0, fill} <= lo_c) || !$past(flow_feat_en && flow_mcr_en)));

  p_flow_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flow_feat_en && flow_mcr_en) |=> !flow_n);

endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/uart_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module uart_rx_buffer_tb_top;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_err = 0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [CW-1:0] fill;
  logic overrun, irq, flow_n;
  logic fifo_on = 1, rx_irq_en = 1, flow_feat_en = 1, flow_mcr_en = 1;
  logic [CW-1:0] trig = 8, hyst = 2;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [10:0] q[$];
  logic [10:0] m_last = 0;
  int m_cnt = 0;
  bit m_flow = 0, m_ovr = 0;

  always #5 clk = ~clk;

  uart_rx_buffer #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flow_model();
    int hi, lo;
    hi = trig + hyst;
    lo = (trig > hyst) ? trig - hyst : 0;
    if (!(flow_feat_en && flow_mcr_en)) m_flow = 0;
    else if (m_cnt >= hi) m_flow = 1;
    else if (m_cnt <= lo) m_flow = 0;
  endtask

  task automatic op(bit w, bit r, logic [7:0] d, logic [2:0] e);
    @(negedge clk);
    if (r && q.size() > 0) begin
      chk("R2 data", rd_data, q[0][7:0]);
      chk("R2 err", rd_err, q[0][10:8]);
    end
    wr_en = w; rd_en = r; wr_data = d; wr_err = e;
    @(posedge clk);
    begin
      bit dr, dw;
      dr = r && m_cnt > 0;
      dw = w && m_cnt < DEPTH;
      if (w && m_cnt == DEPTH) m_ovr = 1;
      if (dr) m_last = q.pop_front();
      if (dw) q.push_back({e, d});
      m_cnt = m_cnt + int'(dw) - int'(dr);
      flow_model();
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R3 fill", fill, m_cnt);
    chk("R7 irq", irq, int'(fifo_on && rx_irq_en && m_cnt >= trig));
    chk("R8/R9 flow_n", flow_n, m_flow);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fill", fill, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flow_n", flow_n, 0);
    chk("R1 overrun", overrun, 0);
    rst_n = 1;

    for (int i = 0; i < DEPTH; i++) begin
      op(1, 0, 8'(8'h3C ^ (i * 37)), 3'(i));
      if (m_cnt == 10) chk("R8 deassert at trig+hyst", flow_n, 1);
      if (m_cnt == 8)  chk("R7 irq at trig", irq, 1);
    end
    op(1, 0, 8'hEE, 3'd7);
    chk("R4 fill at full", fill, DEPTH);
    chk("R4 overrun", overrun, 1);
    op(1, 1, 8'hDD, 3'd5);
    chk("R4 rw at full drops write", fill, DEPTH - 1);

    for (int i = 0; i < 5; i++) op(0, 1, 0, 0);
    chk("R9 hold in band", flow_n, 1);
    op(1, 1, 8'h5A, 3'd2);
    chk("R6 rw count", fill, 10);
    op(1, 1, 8'hA5, 3'd6);
    chk("R6 rw count", fill, 10);

    while (m_cnt > 0) begin
      op(0, 1, 0, 0);
      if (m_cnt == 7) chk("R9 still high at 7", flow_n, 1);
      if (m_cnt == 6) chk("R9 reassert at trig-hyst", flow_n, 0);
      if (m_cnt == 7) chk("R7 irq clears below trig", irq, 0);
    end
    op(0, 1, 0, 0);
    chk("R5 empty fill", fill, 0);
    chk("R5 last data", rd_data, m_last[7:0]);
    chk("R5 last err", rd_err, m_last[10:8]);
    chk("R4 overrun sticky", overrun, 1);
    op(1, 1, 8'h77, 3'd1);
    chk("R5 write with empty read", fill, 1);

    rx_irq_en = 0;
    for (int i = 0; i < 10; i++) op(1, 0, 8'(i), 3'(i));
    chk("R7 irq masked", irq, 0);
    rx_irq_en = 1; fifo_on = 0;
    @(negedge clk);
    chk("R7 irq masked by mode", irq, 0);
    fifo_on = 1;
    @(negedge clk);
    chk("R7 irq enabled", irq, 1);
    chk("R10 flow high before disable", flow_n, 1);
    flow_mcr_en = 0;
    op(0, 0, 0, 0);
    chk("R10 flow disabled", flow_n, 0);
    flow_mcr_en = 1; flow_feat_en = 0;
    op(1, 0, 8'h11, 3'd0);
    chk("R10 flow disabled feat", flow_n, 0);
    flow_feat_en = 1;
    while (m_cnt > 0) op(0, 1, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule